// File: doc/BRIEF.md
# Serial-in latched output driver

This block is the logic core of a cascadable display driver. Serial data is moved into a register chain one bit at a time. A bank of storage latches takes a copy of the chain while the transfer control is held high, and holds that copy while the control is low. An output gate forces every parallel output low while the blank input is high. The latch copy is not changed by blanking, so the display shows it again as soon as blanking ends. The last stage of the chain drives a serial output, and that output feeds the next device when several are chained.

The block runs on one system clock. A rising edge of the external serial clock is given to the block as a one-cycle `shift_en` pulse. The latches are written on the system clock. While `strobe` is high, each latch takes the value its stage holds after that same edge. From outside, the latch bank therefore looks transparent. The chain length is the parameter `WIDTH` (default 10), and it must be at least 2.

Top module: `serial_latch_driver`

## Requirements
- R1: While reset is applied, and until the first shift or transfer afterwards, every stage and every latch is 0. `drv_out` and `ser_out` are therefore 0.
- R2: At a clock edge with `shift_en` high, stage 0 takes `ser_in` and stage k takes the old value of stage k-1.
- R3: At a clock edge with `shift_en` low, no stage changes, whatever `ser_in` is.
- R4: `ser_out` always shows stage WIDTH-1. A bit entered at stage 0 appears on `ser_out` after WIDTH-1 further shifts.
- R5: At a clock edge with `strobe` high, every latch takes the value its stage holds after that same edge. The latches keep following the chain for as long as `strobe` stays high.
- R6: At a clock edge with `strobe` low, the latches hold. Shifting in that case does not change `drv_out`.
- R7: While `blank` is high, every bit of `drv_out` is 0, in the same cycle.
- R8: `blank` never changes the latch contents. When `blank` falls, `drv_out` shows the held latches again.
- R9: With `strobe` held high and `blank` high during loading, `drv_out` stays 0 on every shift. When `blank` then falls, `drv_out` shows the whole chain.
- R10: `drv_out[k]` is driven by latch k, and latch k is fed by stage k. After shifting in a single 1 followed by WIDTH-1 zeros and then transferring, only `drv_out[WIDTH-1]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| shift_en | input | 1 | One-cycle pulse per serial clock rising edge |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High: latches follow the chain; low: latches hold |
| blank | input | 1 | High: all parallel outputs forced low |
| ser_out | output | 1 | Cascade output, stage WIDTH-1 |
| drv_out | output | WIDTH | Logical state of the parallel outputs |

## Verification
The bench shifts in data while `strobe` is low and checks that `drv_out` does not move. A design whose latches are loaded without regard to `strobe` would show the new data too early. It checks whether a transfer delivers the chain contents after the same edge or a cycle late, and a design that picks the wrong stage would be off by one bit. It toggles `blank` over held data. A design that clears the latches when blanking would come back dark, and one that gates the outputs badly would let bits through. Bypass loading with blanking shows whether shifting can be seen through transparent latches. A single marker bit travelling to `ser_out` shows whether the chain runs in the wrong direction or has the wrong length.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned SLD_DEFAULT_WIDTH = 10;
  localparam int unsigned SLD_SYNC_STAGES   = 2;
endpackage

// File: rtl/sld_reset_sync.sv
module sld_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stage_q,
  output logic [WIDTH-1:0] stage_d
);
  always_comb begin
    if (shift_en) stage_d = {stage_q[WIDTH-2:0], ser_in};
    else          stage_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // R2: each shift moves the chain one place and enters ser_in at stage 0
  p_shift_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (stage_q[0] == $past(ser_in)) &&
                 (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])));

  // R3: without a shift pulse the chain holds
  p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage_q));
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] latch_q
);
  logic [WIDTH-1:0] latch_d;

  always_comb begin
    if (strobe) latch_d = load_val;
    else        latch_d = latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  // R6: latches hold while the transfer control is low
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(latch_q));
endmodule

// File: rtl/sld_blank_gate.sv
module sld_blank_gate #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             blank,
  input  logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] drv_out
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign drv_out[k] = latch_q[k] & ~blank;
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int unsigned WIDTH       = sld_pkg::SLD_DEFAULT_WIDTH,
  parameter int unsigned SYNC_STAGES = sld_pkg::SLD_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  input  logic             strobe,
  input  logic             blank,
  output logic             ser_out,
  output logic [WIDTH-1:0] drv_out
);
  logic             rst_core_n;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic [WIDTH-1:0] latch_q;

  sld_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sld_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .stage_q  (stage_q),
    .stage_d  (stage_d)
  );

  // next-state of the chain feeds the latches: transparent from outside
  sld_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .strobe   (strobe),
    .load_val (stage_d),
    .latch_q  (latch_q)
  );

  sld_blank_gate #(.WIDTH(WIDTH)) u_gate (
    .blank   (blank),
    .latch_q (latch_q),
    .drv_out (drv_out)
  );

  assign ser_out = stage_q[WIDTH-1];

  // R5: after a transfer edge the latches match the chain
  p_latch_follow_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    strobe |=> (latch_q == stage_q));

  // R7: blanking darkens every output
  p_blank_off_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    blank |-> (drv_out == '0));

  // R8: blanking with the latches closed leaves their contents alone
  p_blank_keep_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (blank && !strobe) |=> (latch_q == $past(latch_q)));

  // R4: cascade output carries what the next-to-last stage held
  p_cascade_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    shift_en |=> (ser_out == $past(stage_q[WIDTH-2])));

  // R1: outputs are dark while reset is held
  p_reset_dark_r1: assert property (@(posedge clk)
    !rst_core_n |-> (drv_out == '0 && !ser_out));
endmodule

// File: tb/serial_latch_driver_bench.sv
module serial_latch_driver_bench;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         shift_en, ser_in, strobe, blank;
  logic         ser_out;
  logic [N-1:0] drv_out;

  int checks = 0;
  int failures = 0;
  bit ref_sr[$];
  bit ref_lat[N];

  always #10 clk = ~clk;

  serial_latch_driver #(.WIDTH(N)) u_serial_latch_driver (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
    .strobe(strobe), .blank(blank), .ser_out(ser_out), .drv_out(drv_out)
  );

  function automatic logic [N-1:0] ref_out();
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = blank ? 1'b0 : ref_lat[k];
    return v;
  endfunction

  task automatic check_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s drv_out actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ser_out actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic step(string req, bit sh, bit din, bit stb, bit blk);
    shift_en = sh; ser_in = din; strobe = stb; blank = blk;
    @(posedge clk);
    if (sh) begin
      ref_sr.push_front(din);
      void'(ref_sr.pop_back());
    end
    if (stb) for (int k = 0; k < N; k++) ref_lat[k] = ref_sr[k];
    @(negedge clk);
    check_vec(req, drv_out, ref_out());
    check_bit(req, ser_out, ref_sr[N-1]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin ref_sr.push_back(1'b0); ref_lat[k] = 1'b0; end
    rst_n = 1'b0; shift_en = 1'b0; ser_in = 1'b1; strobe = 1'b1; blank = 1'b0;
    repeat (3) @(negedge clk);
    // R1: held in reset with active inputs, outputs dark
    check_vec("R1", drv_out, '0);
    check_bit("R1", ser_out, 1'b0);
    rst_n = 1'b1; strobe = 1'b0; ser_in = 1'b0;
    repeat (3) @(negedge clk);
    check_vec("R1", drv_out, '0);

    // R2/R6: shift a pattern with latches closed; outputs stay dark
    for (int i = 0; i < N; i++) step("R6", 1'b1, (i % 3) == 0, 1'b0, 1'b0);
    // R5: transfer
    step("R5", 1'b0, 1'b0, 1'b1, 1'b0);
    // R3: no shift pulse, ser_in toggles
    for (int i = 0; i < 4; i++) step("R3", 1'b0, i[0], 1'b0, 1'b0);
    // R5: continued following while strobe high and shifting
    for (int i = 0; i < 5; i++) step("R5", 1'b1, i[1], 1'b1, 1'b0);

    // R7/R8: blank over held latches, then release
    for (int i = 0; i < 3; i++) step("R7", 1'b1, 1'b1, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b0, 1'b0, 1'b0);

    // R10/R4: single marker travels to the last stage
    step("R10", 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < N - 1; i++) step("R4", 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R4", ser_out, 1'b1);
    step("R10", 1'b0, 1'b0, 1'b1, 1'b0);
    check_vec("R10", drv_out, {1'b1, {(N-1){1'b0}}});

    // R9: bypass loading with blanking held high
    for (int i = 0; i < N; i++) begin
      step("R9", 1'b1, (i % 2) == 1, 1'b1, 1'b1);
      check_vec("R9", drv_out, '0);
    end
    step("R9", 1'b0, 1'b0, 1'b1, 1'b0);
    check_vec("R9", drv_out, {N/2{2'b01}});

    // mixed random traffic against the model
    for (int i = 0; i < 400; i++)
      step("R2", 1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule